// File: doc/BRIEF.md
# Timer interrupt flag controller

This block keeps the interrupt status flags and the matching enable bits for one 16-bit timer/counter that has three output-compare channels, an input-capture unit and overflow detection. The counter, the waveform logic and the capture data path live elsewhere. This block sees them only through its inputs: the counter value, the three compare values, the capture register value, a capture-event strobe, a flag that marks the capture register as the period limit (TOP), and a timer-tick enable.

Each flag is set by its own event. It is cleared when software writes a one to the flag's bit position, or when the interrupt controller pulses the per-source acknowledge after it services the vector. A source raises its request only when its flag is set, its enable bit is set and the global interrupt enable is on. Software writes and reads the flag and enable registers through a plain register port.

Top module: `tmr_irq_flags`

## Requirements
- R1: After reset, every flag, every enable bit and every request output is 0.
- R2: Flag and enable registers share one 8-bit layout: bit 0 overflow, bit 1 compare A, bit 2 compare B, bit 3 compare C, bit 5 capture. Bits 7, 6 and 4 always read 0, and writes to them are ignored. The request and acknowledge vectors are ordered bit 0 overflow, bit 1 A, bit 2 B, bit 3 C, bit 4 capture.
- R3: A compare flag is set on the next tick after a tick in which the counter equals that channel's compare value. With a tick on every cycle, it is visible two clock edges after the match is presented.
- R4: When a channel's force strobe is high during the matching tick, that channel's flag is not set.
- R5: A match that is present only on cycles where the tick enable is low has no effect.
- R6: The overflow flag is set on the tick at which the counter reads 0, provided the previous tick saw the all-ones value.
- R7: When the capture register is not acting as TOP, the capture flag is set by the capture-event strobe. When it is acting as TOP, the capture flag is set on a tick where the counter equals the capture value, and the strobe is ignored.
- R8: A flag-register write of one at a flag's position clears that flag. A write of zero leaves it unchanged.
- R9: An acknowledge pulse for a source clears that source's flag.
- R10: If a set condition and a clear (write-one or acknowledge) fall in the same cycle, the flag ends up set.
- R11: A request is high only when its flag, its enable bit and the global enable are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timer-clock enable, one per timer step |
| count | input | 16 | Counter value |
| cmp_a | input | 16 | Compare value, channel A |
| cmp_b | input | 16 | Compare value, channel B |
| cmp_c | input | 16 | Compare value, channel C |
| force_cmp | input | 3 | Forced-compare strobes, bit 0 A, bit 1 B, bit 2 C |
| cap_evt | input | 1 | Capture-event strobe |
| cap_is_top | input | 1 | Capture register is used as TOP |
| cap_val | input | 16 | Capture register value |
| gie | input | 1 | Global interrupt enable |
| ack | input | 5 | Per-source vector acknowledge pulses |
| flag_we | input | 1 | Write strobe, flag register (write one to clear) |
| en_we | input | 1 | Write strobe, enable register |
| wdata | input | 8 | Write data |
| flag_rd | output | 8 | Flag register read value |
| en_rd | output | 8 | Enable register read value |
| irq | output | 5 | Per-source interrupt requests |

## Verification
On every cycle, the assertions check the compare pipeline: a pending match becomes a flag at the next tick, a force strobe blocks the pending match, and the pending state holds between ticks. They also check that write-one and acknowledge clear a flag, that a write of zero keeps it, and that no request appears without the global enable. Only the bench's scenarios can show the exact tick at which each flag appears, the overflow wrap condition, the switch of the capture set source in TOP mode, set-over-clear priority, the register bit layout and the reserved bits.

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags #(
  parameter int CNT_W = 16,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic [CNT_W-1:0] cmp_c,
  input  logic [2:0]       force_cmp,
  input  logic             cap_evt,
  input  logic             cap_is_top,
  input  logic [CNT_W-1:0] cap_val,
  input  logic             gie,
  input  logic [4:0]       ack,
  input  logic             flag_we,
  input  logic             en_we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] flag_rd,
  output logic [REG_W-1:0] en_rd,
  output logic [4:0]       irq
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int PAD_W = REG_W - 6;

  logic [4:0]       flg, en, set_v, clr_v, wr_bits;
  logic [2:0]       pend, eq;
  logic [CNT_W-1:0] last_cnt;

  assign eq = {count == cmp_c, count == cmp_b, count == cmp_a} & ~force_cmp;

  assign wr_bits = {wdata[5], wdata[3], wdata[2], wdata[1], wdata[0]};

  assign set_v[0]   = tick && (last_cnt == CNT_MAX) && (count == '0);
  assign set_v[3:1] = tick ? pend : 3'b000;
  assign set_v[4]   = cap_is_top ? (tick && count == cap_val) : cap_evt;

  assign clr_v = ack | (flag_we ? wr_bits : 5'b0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= '0;
      last_cnt <= '0;
    end else if (tick) begin
      pend     <= eq;
      last_cnt <= count;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg <= '0;
    else        flg <= (flg & ~clr_v) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en <= '0;
    else if (en_we) en <= wr_bits;
  end

  assign flag_rd = {{PAD_W{1'b0}}, flg[4], 1'b0, flg[3:0]};
  assign en_rd   = {{PAD_W{1'b0}}, en[4], 1'b0, en[3:0]};
  assign irq     = gie ? (flg & en) : 5'b0;

  assert_cmp_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pend[0]) |=> flag_rd[1]);

  assert_force_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && force_cmp[0]) |=> !pend[0]);

  assert_gap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pend));

  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && wdata[1] && !(tick && pend[0])) |=> !flag_rd[1]);

  assert_wzero_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !wdata[1] && !ack[1] && flag_rd[1]) |=> flag_rd[1]);

  assert_ack_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[2] && !(tick && pend[1])) |=> !flag_rd[2]);

  assert_gie_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq) |-> gie);

endmodule

// File: tb/test_tmr_irq_flags.sv
`timescale 1ns/1ps
module test_tmr_irq_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic [15:0] count = 16'd1;
  logic [15:0] cmp_a = 16'd100, cmp_b = 16'd200, cmp_c = 16'd300;
  logic [2:0]  force_cmp = '0;
  logic        cap_evt = 1'b0, cap_is_top = 1'b0;
  logic [15:0] cap_val = 16'd500;
  logic        gie = 1'b0;
  logic [4:0]  ack = '0;
  logic        flag_we = 1'b0, en_we = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  flag_rd, en_rd;
  logic [4:0]  irq;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_irq_flags i_tmr_irq_flags (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count(count),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c), .force_cmp(force_cmp),
    .cap_evt(cap_evt), .cap_is_top(cap_is_top), .cap_val(cap_val),
    .gie(gie), .ack(ack), .flag_we(flag_we), .en_we(en_we), .wdata(wdata),
    .flag_rd(flag_rd), .en_rd(en_rd), .irq(irq));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    flag_we = 1'b1; wdata = 8'hFF; step(); flag_we = 1'b0; wdata = '0;
  endtask

  task automatic t_reset();
    check("R1 flags", flag_rd, 8'h00);
    check("R1 enables", en_rd, 8'h00);
    check("R1 irq", {3'b0, irq}, 8'h00);
  endtask

  task automatic t_layout();
    en_we = 1'b1; wdata = 8'hFF; step(); en_we = 1'b0;
    check("R2 enable reserved bits", en_rd, 8'h2F);
    en_we = 1'b1; wdata = 8'h00; step(); en_we = 1'b0;
    cap_evt = 1'b1; step(); cap_evt = 1'b0;
    check("R2 capture at bit5", flag_rd, 8'h20);
    clear_all();
  endtask

  task automatic t_cmp_timing();
    count = 16'd100; step(); count = 16'd101;
    check("R3 not yet after match tick", flag_rd, 8'h00);
    step();
    check("R3 compare A set next tick", flag_rd, 8'h02);
    clear_all();
    count = 16'd300; tick = 1'b1; step(); tick = 1'b0; count = 16'd7;
    step(); step(); step();
    check("R3 waits for next tick", flag_rd, 8'h00);
    tick = 1'b1; step();
    check("R3 compare C on next tick", flag_rd, 8'h08);
    clear_all();
  endtask

  task automatic t_force();
    count = 16'd200; force_cmp = 3'b010; step(); force_cmp = '0; count = 16'd5;
    step(); step();
    check("R4 forced B no flag", flag_rd, 8'h00);
  endtask

  task automatic t_gap();
    tick = 1'b0; count = 16'd100; step(); step(); count = 16'd5; tick = 1'b1;
    step(); step();
    check("R5 match off tick ignored", flag_rd, 8'h00);
  endtask

  task automatic t_ovf();
    count = 16'hFFFF; step(); count = 16'h0000;
    check("R6 no flag at max", flag_rd, 8'h00);
    step();
    check("R6 overflow on wrap", flag_rd, 8'h01);
    count = 16'd1; clear_all();
    count = 16'd0; step(); step(); count = 16'd1;
    check("R6 zero without wrap", flag_rd, 8'h00);
  endtask

  task automatic t_cap_top();
    cap_is_top = 1'b1; cap_val = 16'd50; count = 16'd9; cap_evt = 1'b1; step(); cap_evt = 1'b0;
    check("R7 strobe ignored in TOP mode", flag_rd, 8'h00);
    count = 16'd50; step(); count = 16'd1;
    check("R7 TOP reached sets capture", flag_rd, 8'h20);
    cap_is_top = 1'b0; cap_val = 16'd500; clear_all();
  endtask

  task automatic t_w1c();
    count = 16'd100; step(); count = 16'd1; step();
    flag_we = 1'b1; wdata = 8'h00; step(); flag_we = 1'b0;
    check("R8 write zero keeps", flag_rd, 8'h02);
    flag_we = 1'b1; wdata = 8'h02; step(); flag_we = 1'b0;
    check("R8 write one clears", flag_rd, 8'h00);
  endtask

  task automatic t_ack();
    count = 16'hFFFF; step(); count = 16'h0; step(); count = 16'd1;
    check("R9 overflow set before ack", flag_rd, 8'h01);
    ack = 5'b00001; step(); ack = '0;
    check("R9 ack clears", flag_rd, 8'h00);
  endtask

  task automatic t_set_wins();
    count = 16'd100; step(); count = 16'd1;
    flag_we = 1'b1; wdata = 8'h02; ack = 5'b00010; step(); flag_we = 1'b0; ack = '0;
    check("R10 set beats clear", flag_rd, 8'h02);
    clear_all();
  endtask

  task automatic t_irq();
    count = 16'd100; step(); count = 16'd1; step();
    gie = 1'b1; step();
    check("R11 no enable no irq", {3'b0, irq}, 8'h00);
    gie = 1'b0; en_we = 1'b1; wdata = 8'h02; step(); en_we = 1'b0;
    check("R11 no gie no irq", {3'b0, irq}, 8'h00);
    gie = 1'b1; step();
    check("R11 irq A", {3'b0, irq}, 8'h02);
    clear_all();
    check("R11 irq drops with flag", {3'b0, irq}, 8'h00);
    gie = 1'b0;
  endtask

  initial begin
    step(); step();
    t_reset();
    rst_n = 1'b1; step();
    t_reset();
    t_layout();
    t_cmp_timing();
    t_force();
    t_gap();
    t_ovf();
    t_cap_top();
    t_w1c();
    t_ack();
    t_set_wins();
    t_irq();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule